// File: doc/BRIEF.md
# SPI Ferroelectric Memory Record Mover

This block is an SPI master that copies whole records between a byte stream on the chip side and an external serial ferroelectric memory. A record is chosen by a small index. A parameter table gives each record's length in bytes. The block lays the records out back to back, starting at memory address 0, so that each record begins where the previous one ends.

A request is a single valid/ready transfer that carries the direction and the record index. Before it drives the bus, the block checks a shared-port lock input. If the lock is granted, the block holds the lock for the whole transfer. Every request ends with a one-cycle done pulse and an OK bit.

Write payload enters on a valid/ready stream. The block raises `wr_ready` only when it is ready to shift the next byte out, and it keeps SCK idle while `wr_valid` is low. Read payload leaves on a valid/ready stream. A received byte stays on `rd_data` until `rd_ready` takes it, and no further byte is clocked in before then. Both streams carry the bytes in record order, from offset 0 upward.

Top module: `fram_xfer_ctrl`

## Requirements
- R1: After reset the bus is idle and the block is ready for a request:
  - `spi_cs_n`=1 and `spi_sck`=0;
  - `lock_hold`=0 and `done`=0;
  - `req_ready`=1, `wr_ready`=0 and `rd_valid`=0.
- R2: The start address of record k is the sum of the lengths of records 0..k-1. After the command byte, the address goes out as three bytes, high byte first. The high byte is `{2'b00, addr[21:16]}`, followed by `addr[15:8]` and `addr[7:0]`.
- R3: If the sum of all record lengths is greater than 0x3FFFF, `cfg_err` rises one cycle after reset is released. It stays low when the sum is exactly 0x3FFFF. While `cfg_err` is high, every request ends not-OK and chip select never falls.
- R4: An accepted write runs in this order:
  - one chip-select frame that holds only the byte 0x06;
  - chip select high for at least CLK_MHZ*GAP_US clock cycles;
  - a second frame of 0x02, three address bytes, then the payload in stream order.
- R5: An accepted read sends one frame of 0x03 followed by three address bytes. It then transmits 0x00 for each payload byte and delivers the received bytes on the read stream in offset order.
- R6: If `lock_free` is low when a request is accepted, the request ends with done=1 and done_ok=0 two cycles after acceptance. In that case `lock_hold` is never asserted and chip select never falls.
- R7: `lock_hold` is high from the cycle after acceptance until `spi_cs_n` has risen at the end of the transfer. The single-cycle `done` pulse arrives exactly one cycle after that rise, in the same cycle in which `lock_hold` drops.
- R8: The bus uses SPI mode 0:
  - SCK idles low and each half period lasts SCK_DIV cycles;
  - bytes go out MSB first;
  - MOSI changes only while SCK is low;
  - MISO is sampled on the rising edge.
- R9: A write byte is taken only on a cycle with `wr_valid && wr_ready`, and SCK stays low while the block waits for it. A read byte held on `rd_data` stays stable, with SCK low, until `rd_ready` is high.
- R10: A request whose index is not below NUM_REC ends not-OK without any bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write record to memory, 0 = read |
| req_idx | input | IDX_W | Record index |
| done | output | 1 | One-cycle end-of-request pulse |
| done_ok | output | 1 | Status that goes with done; 1 = transfer carried out |
| cfg_err | output | 1 | Record table exceeds the memory size |
| lock_free | input | 1 | Shared SPI port is available |
| lock_hold | output | 1 | Block owns the shared SPI port |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken this cycle if valid |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
A wrong sequencer state shows up on the bus within one SPI byte time, about 16*SCK_DIV cycles: a missing or merged write-enable frame, a wrong command or address byte, or a chip-select edge in the wrong place. A wrong base-address or length register shows up once the frame closes, as a wrong address or a wrong byte count. Later reads of the same records then return mismatched data. Lock and done faults appear within a cycle of the chip-select rise, because the bench compares those cycle numbers exactly.

// File: rtl/fram_pkg.sv
package fram_pkg;
  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [31:0] MEM_LIMIT = 32'h0003_FFFF;
  localparam int ADDR_W = 22;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REJECT, ST_WREN, ST_GAP, ST_CMD,
    ST_ADH, ST_ADM, ST_ADL, ST_PAY, ST_RDOUT, ST_TAIL
  } xfer_st_e;
endpackage

// File: rtl/fram_rec_map.sv
module fram_rec_map #(
  parameter int NUM_REC = 4,
  parameter int LEN_W = 20,
  parameter int IDX_W = 3,
  parameter logic [NUM_REC*LEN_W-1:0] REC_LENS = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           idx,
  output logic                       idx_ok,
  output logic [fram_pkg::ADDR_W-1:0] base,
  output logic [LEN_W-1:0]           len,
  output logic                       cfg_err
);
  import fram_pkg::*;

  logic [31:0] run [NUM_REC+1];
  logic [NUM_REC:0] over;

  assign run[0]  = '0;
  assign over[0] = 1'b0;
  for (genvar g = 0; g < NUM_REC; g++) begin : g_sum
    assign run[g+1]  = run[g] + 32'(REC_LENS[g*LEN_W +: LEN_W]);
    assign over[g+1] = run[g+1] > MEM_LIMIT;
  end

  always_comb begin
    base   = '0;
    len    = '0;
    idx_ok = 1'b0;
    for (int i = 0; i < NUM_REC; i++) begin
      if (idx == IDX_W'(i)) begin
        base   = run[i][ADDR_W-1:0];
        len    = REC_LENS[i*LEN_W +: LEN_W];
        idx_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= |over;
  end
endmodule

// File: rtl/fram_spi_byte.sv
module fram_spi_byte #(
  parameter int SCK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = $clog2(SCK_DIV) + 1;

  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rx <= '0; sck <= 1'b0;
      div_cnt <= '0; bit_cnt <= '0; sh <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; sh <= tx; div_cnt <= '0; bit_cnt <= '0; sck <= 1'b0;
      end else if (busy) begin
        if (div_cnt == DIV_W'(SCK_DIV - 1)) begin
          div_cnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_cnt == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              sh      <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end

  assert_mosi_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  assert_sck_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
endmodule

// File: rtl/fram_xfer_ctrl.sv
module fram_xfer_ctrl #(
  parameter int NUM_REC = 4,
  parameter int LEN_W = 20,
  parameter logic [NUM_REC*LEN_W-1:0] REC_LENS = {20'd4, 20'd2, 20'd5, 20'd3},
  parameter int CLK_MHZ = 200,
  parameter int GAP_US = 5,
  parameter int SCK_DIV = 2,
  localparam int IDX_W = $clog2(NUM_REC) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  output logic             done,
  output logic             done_ok,
  output logic             cfg_err,
  input  logic             lock_free,
  output logic             lock_hold,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  import fram_pkg::*;

  localparam int GAP_CYC = CLK_MHZ * GAP_US;
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  xfer_st_e st, nxt;
  logic              is_wr, launched, cs_n_q, lock_q, done_q, ok_q, rd_valid_q;
  logic [ADDR_W-1:0] base_q, map_base;
  logic [LEN_W-1:0]  len_q, cnt, map_len;
  logic [GAP_W-1:0]  gap_cnt;
  logic [7:0]        rd_data_q, eng_tx, eng_rx;
  logic              map_idx_ok, eng_start, eng_busy, eng_done, wr_ready_c, last;

  fram_rec_map #(.NUM_REC(NUM_REC), .LEN_W(LEN_W), .IDX_W(IDX_W), .REC_LENS(REC_LENS)) u_map (
    .clk(clk), .rst_n(rst_n), .idx(req_idx), .idx_ok(map_idx_ok),
    .base(map_base), .len(map_len), .cfg_err(cfg_err));

  fram_spi_byte #(.SCK_DIV(SCK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx), .busy(eng_busy),
    .done(eng_done), .rx(eng_rx), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso));

  assign last = (cnt == len_q - LEN_W'(1));

  function automatic logic in_frame(xfer_st_e s);
    return (s == ST_WREN) || (s == ST_CMD) || (s == ST_ADH) || (s == ST_ADM) ||
           (s == ST_ADL) || (s == ST_PAY) || (s == ST_RDOUT);
  endfunction

  always_comb begin
    nxt = st;
    eng_start = 1'b0;
    eng_tx = 8'h00;
    wr_ready_c = 1'b0;
    case (st)
      ST_IDLE:
        if (req_valid)
          nxt = (lock_free && !cfg_err && map_idx_ok) ? (req_write ? ST_WREN : ST_CMD) : ST_REJECT;
      ST_REJECT: nxt = ST_IDLE;
      ST_WREN: begin
        eng_tx = CMD_WREN; eng_start = !launched;
        if (launched && eng_done) nxt = ST_GAP;
      end
      ST_GAP: if (gap_cnt == GAP_W'(GAP_CYC - 1)) nxt = ST_CMD;
      ST_CMD: begin
        eng_tx = is_wr ? CMD_WRITE : CMD_READ; eng_start = !launched;
        if (launched && eng_done) nxt = ST_ADH;
      end
      ST_ADH: begin
        eng_tx = {2'b00, base_q[21:16]}; eng_start = !launched;
        if (launched && eng_done) nxt = ST_ADM;
      end
      ST_ADM: begin
        eng_tx = base_q[15:8]; eng_start = !launched;
        if (launched && eng_done) nxt = ST_ADL;
      end
      ST_ADL: begin
        eng_tx = base_q[7:0]; eng_start = !launched;
        if (launched && eng_done) nxt = (len_q == '0) ? ST_TAIL : ST_PAY;
      end
      ST_PAY: begin
        if (!launched) begin
          if (is_wr) begin
            wr_ready_c = 1'b1; eng_tx = wr_data; eng_start = wr_valid;
          end else begin
            eng_start = 1'b1;
          end
        end else if (eng_done) begin
          nxt = is_wr ? (last ? ST_TAIL : ST_PAY) : ST_RDOUT;
        end
      end
      ST_RDOUT: if (rd_ready) nxt = last ? ST_TAIL : ST_PAY;
      ST_TAIL: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; is_wr <= 1'b0; launched <= 1'b0; cs_n_q <= 1'b1;
      lock_q <= 1'b0; done_q <= 1'b0; ok_q <= 1'b0; rd_valid_q <= 1'b0;
      base_q <= '0; len_q <= '0; cnt <= '0; gap_cnt <= '0; rd_data_q <= '0;
    end else begin
      st <= nxt;
      cs_n_q <= !in_frame(nxt);
      gap_cnt <= (st == ST_GAP) ? gap_cnt + GAP_W'(1) : '0;
      if (eng_start) launched <= 1'b1;
      else if (eng_done) launched <= 1'b0;
      if (st == ST_IDLE && req_valid) begin
        is_wr <= req_write; base_q <= map_base; len_q <= map_len; cnt <= '0;
        if (nxt != ST_REJECT) lock_q <= 1'b1;
      end
      if (st == ST_PAY && launched && eng_done) begin
        if (is_wr) cnt <= cnt + LEN_W'(1);
        else begin rd_data_q <= eng_rx; rd_valid_q <= 1'b1; end
      end
      if (st == ST_RDOUT && rd_ready) begin
        rd_valid_q <= 1'b0; cnt <= cnt + LEN_W'(1);
      end
      done_q <= (st == ST_REJECT) || (st == ST_TAIL);
      ok_q   <= (st == ST_TAIL);
      if (st == ST_TAIL) lock_q <= 1'b0;
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign wr_ready  = wr_ready_c;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign spi_cs_n  = cs_n_q;
  assign lock_hold = lock_q;
  assign done      = done_q;
  assign done_ok   = ok_q;

  assert_cs_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> lock_hold);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !lock_free) |=> (!lock_hold && spi_cs_n));
  assert_cfg_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && req_valid && req_ready) |=> !lock_hold);
  assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_wr_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !spi_sck));
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && !spi_sck));
  assert_start_idle_engine_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);
endmodule

// File: tb/tb_fram_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_fram_xfer_ctrl;
  localparam int GAP = 1000;
  localparam int EXP_BASE [4] = '{0, 3, 8, 10};
  localparam int EXP_LEN  [4] = '{3, 5, 2, 4};
  // fields: {write, idx[2:0], lock_free, expect_ok}
  localparam logic [5:0] VEC [10] = '{
    {1'b1, 3'd0, 1'b1, 1'b1}, {1'b0, 3'd0, 1'b1, 1'b1},
    {1'b1, 3'd2, 1'b1, 1'b1}, {1'b0, 3'd2, 1'b1, 1'b1},
    {1'b1, 3'd1, 1'b0, 1'b0}, {1'b0, 3'd1, 1'b1, 1'b1},
    {1'b1, 3'd3, 1'b1, 1'b1}, {1'b0, 3'd3, 1'b1, 1'b1},
    {1'b1, 3'd5, 1'b1, 1'b0}, {1'b0, 3'd6, 1'b1, 1'b0}};

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, lock_free = 1, wr_valid = 0, rd_ready = 0;
  logic [2:0] req_idx = 0;
  logic [7:0] wr_data = 0;
  logic spi_miso = 0;
  logic req_ready, done, done_ok, cfg_err, lock_hold, wr_ready, rd_valid;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic [7:0] rd_data;

  fram_xfer_ctrl dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_idx(req_idx), .done(done), .done_ok(done_ok), .cfg_err(cfg_err),
    .lock_free(lock_free), .lock_hold(lock_hold), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // over-limit table: total 0x40000
  logic o_valid = 0;
  logic o_ready, o_done, o_ok, o_err, o_lock, o_wrr, o_rdv, o_sck, o_cs, o_mosi;
  logic [7:0] o_rdd;
  fram_xfer_ctrl #(.NUM_REC(2), .REC_LENS({20'h20000, 20'h20000})) dut_ovf (
    .clk(clk), .rst_n(rst_n), .req_valid(o_valid), .req_ready(o_ready), .req_write(1'b0),
    .req_idx(2'd0), .done(o_done), .done_ok(o_ok), .cfg_err(o_err), .lock_free(1'b1),
    .lock_hold(o_lock), .wr_data(8'h00), .wr_valid(1'b0), .wr_ready(o_wrr), .rd_data(o_rdd),
    .rd_valid(o_rdv), .rd_ready(1'b1), .spi_sck(o_sck), .spi_cs_n(o_cs), .spi_mosi(o_mosi),
    .spi_miso(1'b0));
  // exactly at limit: total 0x3FFFF
  logic e_ready, e_done, e_ok, e_err, e_lock, e_wrr, e_rdv, e_sck, e_cs, e_mosi;
  logic [7:0] e_rdd;
  fram_xfer_ctrl #(.NUM_REC(2), .REC_LENS({20'h1FFFF, 20'h20000})) dut_edge (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(e_ready), .req_write(1'b0),
    .req_idx(2'd0), .done(e_done), .done_ok(e_ok), .cfg_err(e_err), .lock_free(1'b1),
    .lock_hold(e_lock), .wr_data(8'h00), .wr_valid(1'b0), .wr_ready(e_wrr), .rd_data(e_rdd),
    .rd_valid(e_rdv), .rd_ready(1'b1), .spi_sck(e_sck), .spi_cs_n(e_cs), .spi_mosi(e_mosi),
    .spi_miso(1'b0));

  int nchk = 0, nerr = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and bus monitor
  logic [7:0] mem [256], exp_mem [256];
  logic [7:0] fb [16], flog [4][16];
  int flen [4];
  int nframes = 0, nb = 0, bitc = 0, cyc = 0, rise_cyc = 0, gap_meas = 0;
  bit mon_on = 0, wel = 0, prev_cs = 1;
  logic [7:0] sh = 0, out_sh = 0;
  int ovf_cs_fell = 0;

  function automatic int faddr();
    return ({fb[1], fb[2], fb[3]}) & 255;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (mon_on) begin
      if (spi_cs_n && !prev_cs) rise_cyc = cyc;
      if (!spi_cs_n && prev_cs) gap_meas = cyc - rise_cyc;
      if (!o_cs) ovf_cs_fell++;
    end
    prev_cs = spi_cs_n;
  end
  always @(negedge spi_cs_n) if (mon_on) begin bitc = 0; nb = 0; spi_miso = 0; end
  always @(posedge spi_sck) if (mon_on && !spi_cs_n) begin
    sh = {sh[6:0], spi_mosi}; bitc++;
    if (bitc == 8) begin bitc = 0; if (nb < 16) fb[nb] = sh; nb++; end
  end
  always @(negedge spi_sck) if (mon_on && !spi_cs_n) begin
    if (bitc == 0) out_sh = (fb[0] == 8'h03 && nb >= 4) ? mem[(faddr() + nb - 4) & 255] : 8'h00;
    else out_sh = out_sh << 1;
    spi_miso = out_sh[7];
  end
  always @(posedge spi_cs_n) if (mon_on) begin
    if (nframes < 4) begin
      flen[nframes] = nb;
      for (int k = 0; k < 16; k++) flog[nframes][k] = fb[k];
    end
    nframes++;
    if (nb == 1 && fb[0] == 8'h06) wel = 1;
    else if (fb[0] == 8'h02 && nb >= 4) begin
      if (wel) for (int k = 4; k < nb && k < 16; k++) mem[(faddr() + k - 4) & 255] = fb[k];
      wel = 0;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected done", cyc);
    summary();
    $finish;
  end

  task automatic run_req(input bit wr, input int idx, input bit lf, input bit exp_ok, input int tag);
    int len, base, done_cyc;
    bit got_ok, lock_at_done, stall_sck_ok;
    logic [7:0] sent [16];
    len = (idx < 4) ? EXP_LEN[idx] : 0;
    base = (idx < 4) ? EXP_BASE[idx] : 0;
    stall_sck_ok = 1;
    nframes = 0;
    @(negedge clk);
    lock_free = lf; req_valid = 1; req_write = wr; req_idx = 3'(idx);
    @(negedge clk);
    req_valid = 0;
    fork
      begin
        if (wr && exp_ok) for (int k = 0; k < len; k++) begin
          sent[k] = 8'(tag * 37 + k * 11 + 5);
          repeat (k % 3) begin
            @(negedge clk);
            if (wr_ready && spi_sck) stall_sck_ok = 0;
          end
          wr_valid = 1; wr_data = sent[k];
          while (!wr_ready) @(negedge clk);
          @(negedge clk);
          wr_valid = 0;
        end
      end
      begin
        if (!wr && exp_ok) for (int k = 0; k < len; k++) begin
          while (!rd_valid) @(negedge clk);
          repeat (k % 2 + 1) begin
            @(negedge clk);
            if (spi_sck) stall_sck_ok = 0;
          end
          check(rd_data == exp_mem[base + k], "R5 read byte", rd_data, exp_mem[base + k]);
          rd_ready = 1;
          @(negedge clk);
          rd_ready = 0;
        end
      end
      begin
        do @(negedge clk); while (!done);
        done_cyc = cyc; got_ok = done_ok; lock_at_done = lock_hold;
      end
    join
    check(got_ok == exp_ok, (idx >= 4) ? "R10 status" : "R6 status", got_ok, exp_ok);
    if (!exp_ok) begin
      check(nframes == 0, (idx >= 4) ? "R10 no frames" : "R6 no frames", nframes, 0);
    end else begin
      check(done_cyc == rise_cyc + 1 && !lock_at_done, "R7 done after cs rise", done_cyc - rise_cyc, 1);
      check(stall_sck_ok, "R9 sck idle during stall", 0, 1);
      if (wr) begin
        check(nframes == 2 && flen[0] == 1 && flog[0][0] == 8'h06, "R4 R8 wren frame",
              flog[0][0], 8'h06);
        check(gap_meas >= GAP, "R4 gap cycles", gap_meas, GAP);
        check(flog[1][0] == 8'h02 && flen[1] == len + 4, "R4 write frame", flog[1][0], 8'h02);
        check({flog[1][1], flog[1][2], flog[1][3]} == 24'(base), "R2 write address",
              {flog[1][1], flog[1][2], flog[1][3]}, base);
        for (int k = 0; k < len; k++) begin
          check(flog[1][4 + k] == sent[k], "R4 payload", flog[1][4 + k], sent[k]);
          exp_mem[base + k] = sent[k];
        end
      end else begin
        check(nframes == 1 && flog[0][0] == 8'h03 && flen[0] == len + 4, "R5 read frame",
              flog[0][0], 8'h03);
        check({flog[0][1], flog[0][2], flog[0][3]} == 24'(base), "R2 read address",
              {flog[0][1], flog[0][2], flog[0][3]}, base);
        for (int k = 0; k < len; k++)
          check(flog[0][4 + k] == 8'h00, "R5 dummy tx", flog[0][4 + k], 0);
      end
    end
    @(negedge clk);
    check(spi_sck == 0 && spi_cs_n == 1 && lock_hold == 0, "R8 bus idle after request",
          {spi_sck, spi_cs_n, lock_hold}, 3'b010);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hA0 ^ 8'(i); exp_mem[i] = 8'hA0 ^ 8'(i); end
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1 && spi_sck == 0 && lock_hold == 0 && done == 0, "R1 bus reset",
          {spi_cs_n, spi_sck, lock_hold, done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;
    check(req_ready == 1 && wr_ready == 0 && rd_valid == 0, "R1 handshake reset",
          {req_ready, wr_ready, rd_valid}, 3'b100);
    @(negedge clk);
    check(cfg_err == 0, "R3 table fits", cfg_err, 0);
    check(o_err == 1, "R3 overflow flag", o_err, 1);
    check(e_err == 0, "R3 exact limit", e_err, 0);

    for (int v = 0; v < 10; v++)
      run_req(VEC[v][5], int'(VEC[v][4:2]), VEC[v][1], VEC[v][0], v);

    // R3: a request to the over-limit instance is rejected without bus activity
    @(negedge clk); o_valid = 1;
    @(negedge clk); o_valid = 0;
    begin
      bit seen, okv;
      seen = 0; okv = 1;
      repeat (4) begin
        @(negedge clk);
        if (o_done) begin seen = 1; okv = o_ok; end
      end
      check(seen && !okv, "R3 overflow rejects", okv, 0);
      check(ovf_cs_fell == 0, "R3 overflow no cs", ovf_cs_fell, 0);
    end
    summary();
    $finish;
  end
endmodule